// File: doc/BRIEF.md
# I2C Register-File Target

This block is the serial front end of a small timekeeping register file. It watches SCL and SDA (both already brought into the system clock domain by the caller) and answers a host on the two-wire bus at the fixed 7-bit address 1101000. It only ever pulls SDA low, through an open-drain enable. The register file sits outside the block: writes leave as a one-cycle strobe carrying address and data, and each read byte is fetched through a one-cycle request.

A write transaction sends the address byte D0h. The first data byte after it loads a 4-bit register pointer. Every later byte is written at the pointer, which then advances. A read uses address D1h, either on its own or after a repeated START that follows a pointer write. It returns bytes from the pointer onward, advancing once per byte. The pointer keeps its value between transactions.

The write strobe and the read request carry no ready signal. Without clock stretching there is nothing the block can hold back, so there is no back-pressure. The consumer must take each write strobe in the cycle it is high. `rd_data` must be valid, combinationally, in the same cycle that `rd_req` is high.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is held, `sda_drive_low`, `wr_valid` and `rd_req` are all 0.
- R2: An address byte of D0h (write) or D1h (read) is acknowledged. The block drives SDA low from the SCL falling edge after the eighth bit and releases it after the SCL falling edge that ends the ninth clock.
- R3: In a write, the first data byte loads the pointer and is acknowledged. Each later byte is acknowledged and produces one write strobe with `wr_addr` equal to the pointer and `wr_data` equal to the byte, MSB received first. The pointer then increments.
- R4: An address byte whose upper seven bits are not 1101000 gets no acknowledge. No strobe or request follows until the next START.
- R5: In a read, whether plain or after a repeated START, bytes are sent MSB first. They start at the pointer, and the pointer increments after each byte.
- R6: When the host does not acknowledge a read byte, SDA is released and no further read request is made until a new START.
- R7: The pointer is 4 bits wide. It wraps from 0Fh to 00h on increment and keeps its value across transactions, so a plain read continues where the last access stopped.
- R8: A pointer byte above 0Fh gets no acknowledge. The pointer is unchanged, and the rest of that transaction produces no strobe.
- R9: A START or STOP in the middle of a byte abandons that byte. No write strobe is made for it and the pointer does not move. A START returns the block to address matching.
- R10: `wr_valid` and `rd_req` are each high for exactly one clock per byte, with no ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Data of the write |
| rd_req | output | 1 | One-cycle request for the byte at `rd_addr` |
| rd_addr | output | 4 | Current register pointer |
| rd_data | input | 8 | Register byte at `rd_addr`, valid in the `rd_req` cycle |

## Verification
The embedded assertions check, on every cycle, that the strobe and the read request last one clock, that SDA is only ever pulled low while SCL is low, that a STOP always releases the line and idles the block, and that a host not-acknowledge releases the line. Only the bench scenarios can show the byte-level behaviour: which address values are acknowledged, where the pointer lands after loads, writes, reads and wraps, that it persists into a plain read, that an oversize pointer is refused without side effects, and that an interrupted byte leaves the register file and pointer untouched.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA moving while SCL stays high marks bus conditions
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_pointer.sv
module i2c_tgt_pointer #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  // R7: natural modulo-2^PTR_W wrap, value kept between transactions
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         PTR_W    = 4,
  parameter int         DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  output logic              wr_valid,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  import i2c_tgt_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              sda_q, is_read, ptr_phase, m_ack;
  logic              wr_valid_q;
  logic [PTR_W-1:0]  wr_addr_q, ptr;
  logic [DATA_W-1:0] wr_data_q;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              byte_done, ptr_ok, ptr_load, ptr_inc;

  i2c_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load),
    .load_val(sh[PTR_W-1:0]), .inc(ptr_inc), .ptr(ptr)
  );

  assign byte_done = scl_fall && (cnt == LAST_BIT);
  // R8: a pointer byte must fit the register file
  assign ptr_ok    = (sh[DATA_W-1:PTR_W] == '0);
  assign ptr_load  = (state == ST_WDATA) && byte_done && ptr_phase && ptr_ok;
  assign ptr_inc   = ((state == ST_WDATA) && byte_done && !ptr_phase) ||
                     ((state == ST_RDATA) && byte_done);
  assign rd_req    = scl_fall && (((state == ST_ADDR_ACK) && is_read) ||
                                  ((state == ST_RACK) && m_ack));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      sda_q      <= 1'b0;
      is_read    <= 1'b0;
      ptr_phase  <= 1'b0;
      m_ack      <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
        sda_q <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        sda_q <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              if (sh[DATA_W-1:1] == DEV_ADDR) begin
                sda_q   <= 1'b1;
                is_read <= sh[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                sh    <= rd_data;
                sda_q <= ~rd_data[DATA_W-1];
                state <= ST_RDATA;
              end else begin
                sda_q     <= 1'b0;
                ptr_phase <= 1'b1;
                state     <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              if (ptr_phase) begin
                if (ptr_ok) begin
                  sda_q     <= 1'b1;
                  ptr_phase <= 1'b0;
                  state     <= ST_WACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_q      <= 1'b1;
                wr_valid_q <= 1'b1;
                wr_addr_q  <= ptr;
                wr_data_q  <= sh;
                state      <= ST_WACK;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_q <= 1'b0;
              cnt   <= '0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_q <= 1'b0;
                state <= ST_RACK;
              end else begin
                sh    <= {sh[DATA_W-2:0], 1'b0};
                sda_q <= ~sh[DATA_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_i;
            end else if (scl_fall) begin
              if (m_ack) begin
                sh    <= rd_data;
                sda_q <= ~rd_data[DATA_W-1];
                cnt   <= '0;
                state <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_drive_low = sda_q;
  assign wr_valid      = wr_valid_q;
  assign wr_addr       = wr_addr_q;
  assign wr_data       = wr_data_q;
  assign rd_addr       = ptr;

  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r2_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !$past(scl_i));
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_drive_low);
  a_r6_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RACK) && scl_fall && !m_ack) |=> !sda_drive_low && (state == ST_IDLE));
  a_r3_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (state == ST_WACK) && sda_drive_low);
endmodule

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       drv, wr_valid, rd_req;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       sda_line;
  logic [7:0] mem  [16];
  logic [7:0] refm [16];
  logic [11:0] exp_q [$];
  int  checks = 0, errors = 0;
  bit  prev_wv = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~drv;
  assign rd_data  = mem[rd_addr];

  i2c_regfile_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(drv), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench register file
  always @(posedge clk) if (wr_valid) mem[wr_addr] <= wr_data;

  // per-clock monitor of the write strobe against the expected stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R3 write strobe", {wr_addr, wr_data}, e);
        end
        if (prev_wv) chk(1'b0, "R10 strobe longer than one cycle", 2, 1);
      end
      prev_wv = wr_valid;
    end
  end

  task automatic q(); repeat (10) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bus_rstart(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bus_stop(); sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); endtask
  task automatic send_bit(input bit b); sda_m = b; q(); scl_m = 1; q(); scl_m = 0; q(); endtask
  task automatic get_bit(output bit b); sda_m = 1; q(); scl_m = 1; q(); b = sda_line; scl_m = 0; q(); endtask

  task automatic wbyte(input logic [7:0] v, output bit nak);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(nak);
  endtask

  task automatic rbyte(input bit nak, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      get_bit(b);
      v[i] = b;
    end
    send_bit(nak);
  endtask

  task automatic expect_wr(input logic [3:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    refm[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 8'((i * 37 + 5) & 8'hFF);
      refm[i] = 8'((i * 37 + 5) & 8'hFF);
    end
  end

  initial begin
    bit nk;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(drv == 0 && wr_valid == 0 && rd_req == 0, "R1 reset outputs", {drv, wr_valid, rd_req}, 0);
    rst_n = 1;
    q();

    // R2 / R3: pointer load then two writes
    bus_start();
    wbyte(8'hD0, nk); chk(nk == 0, "R2 write address ack", nk, 0);
    chk(drv == 0, "R2 release after ninth clock", drv, 0);
    wbyte(8'h03, nk); chk(nk == 0, "R3 pointer ack", nk, 0);
    expect_wr(4'h3, 8'hA5); expect_wr(4'h4, 8'h5C);
    wbyte(8'hA5, nk); chk(nk == 0, "R3 data ack", nk, 0);
    wbyte(8'h5C, nk); chk(nk == 0, "R3 data ack", nk, 0);
    bus_stop(); q();
    chk(exp_q.size() == 0, "R3 writes delivered", exp_q.size(), 0);

    // R4: foreign address ignored
    bus_start();
    wbyte(8'hD2, nk); chk(nk == 1, "R4 foreign address nack", nk, 1);
    wbyte(8'h07, nk); chk(nk == 1, "R4 later byte ignored", nk, 1);
    bus_stop(); q();

    // R5 / R6: pointer write, repeated start, read two
    bus_start();
    wbyte(8'hD0, nk); wbyte(8'h03, nk);
    bus_rstart();
    wbyte(8'hD1, nk); chk(nk == 0, "R2 read address ack", nk, 0);
    rbyte(1'b0, v); chk(v == refm[3], "R5 first read byte", v, refm[3]);
    rbyte(1'b1, v); chk(v == refm[4], "R5 second read byte", v, refm[4]);
    chk(drv == 0, "R6 release after host nack", drv, 0);
    bus_stop(); q();

    // R7: plain read continues at pointer 5
    bus_start();
    wbyte(8'hD1, nk);
    rbyte(1'b1, v); chk(v == refm[5], "R7 plain read from kept pointer", v, refm[5]);
    bus_stop(); q();

    // R7: wrap 0F -> 00 on write and read
    bus_start();
    wbyte(8'hD0, nk); wbyte(8'h0F, nk);
    expect_wr(4'hF, 8'h77); expect_wr(4'h0, 8'h88);
    wbyte(8'h77, nk); wbyte(8'h88, nk);
    bus_stop(); q();
    chk(exp_q.size() == 0, "R7 wrapped writes delivered", exp_q.size(), 0);
    bus_start();
    wbyte(8'hD0, nk); wbyte(8'h0E, nk);
    bus_rstart();
    wbyte(8'hD1, nk);
    rbyte(1'b0, v); chk(v == refm[14], "R5 read at 0E", v, refm[14]);
    rbyte(1'b0, v); chk(v == 8'h77, "R7 read at 0F", v, 8'h77);
    rbyte(1'b1, v); chk(v == 8'h88, "R7 read wrapped to 00", v, 8'h88);
    bus_stop(); q();

    // R8: oversize pointer refused, pointer stays at 1
    bus_start();
    wbyte(8'hD0, nk);
    wbyte(8'h10, nk); chk(nk == 1, "R8 oversize pointer nack", nk, 1);
    wbyte(8'h99, nk); chk(nk == 1, "R8 following byte ignored", nk, 1);
    bus_stop(); q();
    bus_start();
    wbyte(8'hD1, nk);
    rbyte(1'b1, v); chk(v == refm[1], "R8 pointer unchanged", v, refm[1]);
    bus_stop(); q();

    // R9: START and STOP in mid-byte abort
    bus_start();
    wbyte(8'hD0, nk); wbyte(8'h02, nk);
    send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    bus_rstart();
    wbyte(8'hD0, nk); chk(nk == 0, "R9 address after abort", nk, 0);
    wbyte(8'h06, nk);
    expect_wr(4'h6, 8'hC3);
    wbyte(8'hC3, nk);
    send_bit(0); send_bit(1); send_bit(1);
    bus_stop(); q();
    chk(exp_q.size() == 0, "R9 no write for cut byte", exp_q.size(), 0);
    bus_start();
    wbyte(8'hD1, nk);
    rbyte(1'b1, v); chk(v == refm[7], "R9 pointer not moved by cut byte", v, refm[7]);
    bus_stop(); q();

    chk(mem[2] == refm[2], "R9 register untouched", mem[2], refm[2]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule